// File: doc/BRIEF.md
# SMT Reorder-Buffer Capacity Partitioner

In a core that runs several hardware threads, the reorder buffer is shared. This block decides how many of its entries each thread may hold. It keeps one registered entry limit per thread. It derives those limits from a selectable sharing policy and from the set of threads that are currently active. From the limits it works out the headroom that allocation logic needs: the free entries left for each thread, the free entries left in the whole buffer, and a per-thread flag that stops allocation.

There are three sharing policies. Under the open policy, every thread may fill the whole buffer. Under the even-split policy, each thread gets an equal integer share. Under the cap policy, each thread is held to a fixed ceiling that software supplies. When the policy changes, all limits are reloaded from the base rule of the new policy. When the active-thread set changes, a strobe with the new mask recomputes the limits of the active threads. The division by the number of active threads uses a constant table of quotients, one per possible thread count. This means a recomputation needs no divider and finishes in a single cycle. The reorder-buffer storage is outside this block, and the occupancy counts come in from it.

Top module: `rob_part_top`

## Requirements
- R1: `policy_sel` encodes the policy as 0 = open, 1 = even split, 2 = cap; code 3 behaves as open. On a reload under the open policy, every thread limit becomes CAPACITY.
- R2: On a reload under the even-split policy, every thread limit becomes CAPACITY / NUM_THREADS, rounded down; any remainder entries stay unassigned.
- R3: On a reload under the cap policy, every thread limit becomes the value on `cap_value` at that cycle. `cap_value` is read only on a reload.
- R4: A reload happens in the first cycle after reset and in any cycle where `policy_sel` differs from the policy last loaded. The new limits are visible in the following cycle. A reload takes priority over an update strobe in the same cycle. With neither a reload nor a strobe, the limits hold.
- R5: A strobe `act_upd` under the even-split policy sets the limit of each thread whose `act_mask` bit is 1 to CAPACITY divided by the number of 1 bits, rounded down. The limits of inactive threads are kept. The new values are visible in the next cycle.
- R6: A strobe under the cap policy with exactly one bit of `act_mask` set raises that thread's limit to CAPACITY. With two or more bits set, the strobe changes no limit.
- R7: A strobe under the open policy changes no limit. A strobe whose mask has no bit set changes no limit under any policy.
- R8: The per-thread free count is the thread limit minus its occupancy, saturating at 0. The global free count is CAPACITY minus total occupancy, saturating at 0. Both are combinational.
- R9: The stall flag of thread i (bit i of `thr_stall`) is 1 when that thread's free count is 0 or the global free count is 0.
- R10: While reset is asserted, all limits are 0, so every stall flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_sel | input | 2 | Sharing policy code |
| cap_value | input | CNT_W | Per-thread ceiling for the cap policy |
| act_mask | input | NUM_THREADS | Active-thread set, bit i for thread i |
| act_upd | input | 1 | Strobe: recompute limits for `act_mask` |
| thr_occ | input | NUM_THREADS*CNT_W | Per-thread occupancy, thread i in bits [i*CNT_W +: CNT_W] |
| tot_occ | input | CNT_W | Total buffer occupancy |
| thr_limit | output | NUM_THREADS*CNT_W | Per-thread entry limits, same packing |
| thr_free | output | NUM_THREADS*CNT_W | Per-thread free entries, same packing |
| tot_free | output | CNT_W | Global free entries |
| thr_stall | output | NUM_THREADS | Per-thread allocation stall |

## Verification
The hardest state to reach is a mix of limits that no single policy load produces. An example is one thread at full capacity while the others sit at a three-way share, or a cap-policy thread raised to the full buffer beside threads still at the ceiling. The stimulus table gets there by chaining strobes with different masks under one policy, so that each step starts from the limits the previous step left behind. It also places a policy change and a strobe in the same cycle, to show that the reload wins. The free and stall checks then drive occupancies above a thread's reduced limit, which exercises the saturating subtraction.

// File: rtl/rob_part_pkg.sv
package rob_part_pkg;

  typedef enum logic [1:0] {
    POL_OPEN  = 2'd0,
    POL_SPLIT = 2'd1,
    POL_CAP   = 2'd2,
    POL_ALT   = 2'd3
  } rob_pol_e;

  // number of set bits in a mask of up to 32 threads
  function automatic int unsigned mask_pop(input logic [31:0] m);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 32; b++) n += int'(m[b]);
    return n;
  endfunction

  // subtraction clipped at zero
  function automatic int unsigned clip_sub(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/rob_part_share.sv
// Quotient table CAPACITY / k for k = 1..NT, selected by the active count.
module rob_part_share #(
  parameter int NT  = 4,
  parameter int CAP = 64,
  parameter int CW  = 7,
  parameter int TW  = 3
) (
  input  logic [TW-1:0] act_cnt,
  output logic [CW-1:0] share
);
  logic [CW-1:0] quot [NT+1];

  for (genvar k = 0; k <= NT; k++) begin : g_q
    if (k == 0) begin : g_zero
      assign quot[k] = '0;
    end else begin : g_div
      assign quot[k] = CW'(CAP / k);
    end
  end

  always_comb begin
    share = '0;
    for (int k = 0; k <= NT; k++) begin
      if (act_cnt == TW'(k)) share = quot[k];
    end
  end
endmodule

// File: rtl/rob_part_limits.sv
module rob_part_limits
  import rob_part_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 64,
  parameter int CW  = 7,
  parameter int TW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy_sel,
  input  logic [CW-1:0]    cap_value,
  input  logic [NT-1:0]    act_mask,
  input  logic             act_upd,
  input  logic [TW-1:0]    act_cnt,
  input  logic [CW-1:0]    share,
  output logic [NT*CW-1:0] lim_flat,
  output logic             reload_ev,
  output logic             apply_ev
);
  localparam logic [CW-1:0] CAPV  = CW'(CAP);
  localparam logic [CW-1:0] SPLIT = CW'(CAP / NT);

  rob_pol_e      pol_q;
  rob_pol_e      pol_in;
  logic          pend_q;
  logic [CW-1:0] lim_q [NT];

  function automatic logic [CW-1:0] base_limit(input rob_pol_e p, input logic [CW-1:0] cv);
    case (p)
      POL_SPLIT: return SPLIT;
      POL_CAP:   return cv;
      default:   return CAPV;
    endcase
  endfunction

  function automatic logic [CW-1:0] upd_limit(input rob_pol_e p, input logic [TW-1:0] n,
                                              input logic [CW-1:0] sh, input logic [CW-1:0] cur);
    case (p)
      POL_SPLIT: return sh;
      POL_CAP:   return (n == TW'(1)) ? CAPV : cur;
      default:   return cur;
    endcase
  endfunction

  assign pol_in    = rob_pol_e'(policy_sel);
  assign reload_ev = pend_q || (pol_in != pol_q);
  // single-thread open configuration skips recomputation entirely
  assign apply_ev  = act_upd && !reload_ev && (act_cnt != '0)
                     && !((NT == 1) && (pol_q == POL_OPEN || pol_q == POL_ALT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      pol_q  <= POL_OPEN;
    end else begin
      pend_q <= 1'b0;
      pol_q  <= pol_in;
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lim_q[i] <= '0;
      end else if (reload_ev) begin
        lim_q[i] <= base_limit(pol_in, cap_value);
      end else if (apply_ev && act_mask[i]) begin
        lim_q[i] <= upd_limit(pol_q, act_cnt, share, lim_q[i]);
      end
    end
    assign lim_flat[i*CW +: CW] = lim_q[i];
  end
endmodule

// File: rtl/rob_part_free.sv
module rob_part_free
  import rob_part_pkg::*;
#(
  parameter int NT  = 4,
  parameter int CAP = 64,
  parameter int CW  = 7
) (
  input  logic [NT*CW-1:0] lim_flat,
  input  logic [NT*CW-1:0] thr_occ,
  input  logic [CW-1:0]    tot_occ,
  output logic [NT*CW-1:0] thr_free,
  output logic [CW-1:0]    tot_free,
  output logic [NT-1:0]    thr_stall
);
  assign tot_free = CW'(clip_sub(CAP, 32'(tot_occ)));

  for (genvar i = 0; i < NT; i++) begin : g_thr
    logic [CW-1:0] f;
    assign f = CW'(clip_sub(32'(lim_flat[i*CW +: CW]), 32'(thr_occ[i*CW +: CW])));
    assign thr_free[i*CW +: CW] = f;
    assign thr_stall[i] = (f == '0) || (tot_free == '0);
  end
endmodule

// File: rtl/rob_part_top.sv
module rob_part_top
  import rob_part_pkg::*;
#(
  parameter int  NUM_THREADS = 4,
  parameter int  CAPACITY    = 64,
  localparam int CNT_W       = $clog2(CAPACITY + 1),
  localparam int TC_W        = $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   policy_sel,
  input  logic [CNT_W-1:0]             cap_value,
  input  logic [NUM_THREADS-1:0]       act_mask,
  input  logic                         act_upd,
  input  logic [NUM_THREADS*CNT_W-1:0] thr_occ,
  input  logic [CNT_W-1:0]             tot_occ,
  output logic [NUM_THREADS*CNT_W-1:0] thr_limit,
  output logic [NUM_THREADS*CNT_W-1:0] thr_free,
  output logic [CNT_W-1:0]             tot_free,
  output logic [NUM_THREADS-1:0]       thr_stall
);
  localparam int NT  = NUM_THREADS;
  localparam int CAP = CAPACITY;
  localparam int CW  = CNT_W;

  logic [TC_W-1:0] act_cnt;
  logic [CW-1:0]   share;
  logic            reload_ev;
  logic            apply_ev;

  assign act_cnt = TC_W'(mask_pop(32'(act_mask)));

  rob_part_share #(.NT(NT), .CAP(CAP), .CW(CW), .TW(TC_W)) u_share (
    .act_cnt(act_cnt),
    .share  (share)
  );

  rob_part_limits #(.NT(NT), .CAP(CAP), .CW(CW), .TW(TC_W)) u_lim (
    .clk       (clk),
    .rst_n     (rst_n),
    .policy_sel(policy_sel),
    .cap_value (cap_value),
    .act_mask  (act_mask),
    .act_upd   (act_upd),
    .act_cnt   (act_cnt),
    .share     (share),
    .lim_flat  (thr_limit),
    .reload_ev (reload_ev),
    .apply_ev  (apply_ev)
  );

  rob_part_free #(.NT(NT), .CAP(CAP), .CW(CW)) u_free (
    .lim_flat (thr_limit),
    .thr_occ  (thr_occ),
    .tot_occ  (tot_occ),
    .thr_free (thr_free),
    .tot_free (tot_free),
    .thr_stall(thr_stall)
  );
endmodule

// File: rtl/rob_part_chk.sv
module rob_part_chk #(
  parameter int NT  = 4,
  parameter int CAP = 64,
  parameter int CW  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy_sel,
  input logic [CW-1:0]    cap_value,
  input logic [NT-1:0]    act_mask,
  input logic             act_upd,
  input logic [NT*CW-1:0] thr_limit,
  input logic [NT*CW-1:0] thr_free,
  input logic [CW-1:0]    tot_free,
  input logic [NT-1:0]    thr_stall,
  input logic             reload_ev
);
  localparam logic [CW-1:0] CAPV  = CW'(CAP);
  localparam logic [CW-1:0] SPLIT = CW'(CAP / NT);

  a_r1_open_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev && (policy_sel == 2'd0 || policy_sel == 2'd3) |=> thr_limit == {NT{CAPV}});

  a_r2_split_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev && policy_sel == 2'd1 |=> thr_limit == {NT{SPLIT}});

  a_r3_cap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_ev && policy_sel == 2'd2 |=> thr_limit[CW-1:0] == $past(cap_value));

  a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_ev && !act_upd |=> $stable(thr_limit));

  a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_ev && act_upd && act_mask == '0 |=> $stable(thr_limit));

  a_r9_global_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tot_free == '0 |-> &thr_stall);

  for (genvar i = 0; i < NT; i++) begin : g_thr
    a_r8_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
      thr_free[i*CW +: CW] <= thr_limit[i*CW +: CW]);
    a_r9_thread_stall: assert property (@(posedge clk) disable iff (!rst_n)
      thr_free[i*CW +: CW] == '0 |-> thr_stall[i]);
  end
endmodule

bind rob_part_top rob_part_chk #(.NT(NT), .CAP(CAP), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .policy_sel(policy_sel),
  .cap_value (cap_value),
  .act_mask  (act_mask),
  .act_upd   (act_upd),
  .thr_limit (thr_limit),
  .thr_free  (thr_free),
  .tot_free  (tot_free),
  .thr_stall (thr_stall),
  .reload_ev (reload_ev)
);

// File: tb/rob_part_top_tb_top.sv
module rob_part_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int CW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      policy_sel = 2'd1;
  logic [CW-1:0]   cap_value = 7'd20;
  logic [NT-1:0]   act_mask = '0;
  logic            act_upd = 1'b0;
  logic [NT*CW-1:0] thr_occ = '0;
  logic [CW-1:0]   tot_occ = '0;
  logic [NT*CW-1:0] thr_limit, thr_free;
  logic [CW-1:0]   tot_free;
  logic [NT-1:0]   thr_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_part_top #(.NUM_THREADS(NT), .CAPACITY(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .cap_value(cap_value),
    .act_mask(act_mask), .act_upd(act_upd), .thr_occ(thr_occ), .tot_occ(tot_occ),
    .thr_limit(thr_limit), .thr_free(thr_free), .tot_free(tot_free), .thr_stall(thr_stall)
  );

  // {policy, cap_value, mask, strobe, expected limits t3..t0}
  localparam int VN = 16;
  localparam logic [41:0] VEC [VN] = '{
    {2'd1, 7'd20, 4'b0011, 1'b1, 7'd16, 7'd16, 7'd32, 7'd32},
    {2'd1, 7'd20, 4'b0111, 1'b1, 7'd16, 7'd21, 7'd21, 7'd21},
    {2'd1, 7'd20, 4'b0000, 1'b1, 7'd16, 7'd21, 7'd21, 7'd21},
    {2'd1, 7'd20, 4'b1111, 1'b0, 7'd16, 7'd21, 7'd21, 7'd21},
    {2'd1, 7'd20, 4'b1000, 1'b1, 7'd64, 7'd21, 7'd21, 7'd21},
    {2'd2, 7'd20, 4'b0000, 1'b0, 7'd20, 7'd20, 7'd20, 7'd20},
    {2'd2, 7'd20, 4'b0100, 1'b1, 7'd20, 7'd64, 7'd20, 7'd20},
    {2'd2, 7'd20, 4'b0101, 1'b1, 7'd20, 7'd64, 7'd20, 7'd20},
    {2'd0, 7'd20, 4'b0000, 1'b0, 7'd64, 7'd64, 7'd64, 7'd64},
    {2'd0, 7'd20, 4'b0001, 1'b1, 7'd64, 7'd64, 7'd64, 7'd64},
    {2'd1, 7'd20, 4'b0011, 1'b1, 7'd16, 7'd16, 7'd16, 7'd16},
    {2'd1, 7'd20, 4'b0011, 1'b1, 7'd16, 7'd16, 7'd32, 7'd32},
    {2'd3, 7'd20, 4'b0000, 1'b0, 7'd64, 7'd64, 7'd64, 7'd64},
    {2'd2, 7'd9,  4'b0001, 1'b1, 7'd9,  7'd9,  7'd9,  7'd9 },
    {2'd2, 7'd9,  4'b0001, 1'b1, 7'd9,  7'd9,  7'd9,  7'd64},
    {2'd2, 7'd30, 4'b0000, 1'b0, 7'd9,  7'd9,  7'd9,  7'd64}
  };

  // requirement each vector exercises
  string vtag [VN] = '{"R5", "R5", "R7", "R4", "R5", "R3", "R6", "R6",
                       "R1", "R7", "R4", "R5", "R1", "R4", "R6", "R3"};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: limits zero in reset, all stalled
    check("R10 limits", 64'(thr_limit), 64'd0);
    check("R10 stall", 64'(thr_stall), 64'hF);
    check("R8 tot_free in reset", 64'(tot_free), 64'd64);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: first cycle after reset loads the split share 64/4
    check("R2 split reload", 64'(thr_limit), 64'({7'd16, 7'd16, 7'd16, 7'd16}));

    for (int v = 0; v < VN; v++) begin
      {policy_sel, cap_value, act_mask, act_upd} = VEC[v][41:28];
      @(negedge clk);
      check($sformatf("%s vector %0d", vtag[v], v), 64'(thr_limit), 64'(VEC[v][27:0]));
    end
    act_upd = 1'b0;
    act_mask = '0;

    // limits now {9,9,9,64}
    thr_occ = {7'd0, 7'd12, 7'd9, 7'd10};
    tot_occ = 7'd31;
    #1;
    check("R8 thread free", 64'(thr_free), 64'({7'd9, 7'd0, 7'd0, 7'd54}));
    check("R8 global free", 64'(tot_free), 64'd33);
    check("R9 thread stall", 64'(thr_stall), 64'b0110);
    tot_occ = 7'd64;
    #1;
    check("R9 global full stall", 64'(thr_stall), 64'hF);
    check("R8 global zero", 64'(tot_free), 64'd0);
    tot_occ = 7'd70;
    #1;
    check("R8 global saturate", 64'(tot_free), 64'd0);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async clear", 64'(thr_limit), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3/R4: reload after reset under cap policy reads cap_value 30
    check("R3 cap reload after reset", 64'(thr_limit), 64'({7'd30, 7'd30, 7'd30, 7'd30}));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule